// File: doc/BRIEF.md
# Prioritized Exception Entry Controller

This block sits next to a simple in-order processor pipeline and decides which exception the core enters, and in which cycle. The core reports synchronous conditions (data abort, prefetch abort, undefined instruction, software interrupt) as single-cycle flags. It also supplies a strobe that marks the end of each instruction and its current status word. Two interrupt lines, a fast one and a normal one, arrive without any timing relation to the clock. A separate level-sensitive reset request restarts the core.

When an entry is chosen, the block raises `take_o` for that one cycle. In the same cycle it presents the vector address, the new mode, the new mask bits, and the strobes that tell the core to capture its return address and status word. The core loads these values at the clock edge that ends the cycle, so the block sees the updated masks on `status_i` from the next cycle on.

Top module: `exc_entry_ctrl`

## Requirements
- R1: The order of precedence is fixed: reset request first, then data abort, fast interrupt, normal interrupt, prefetch abort, and finally undefined instruction or software interrupt. Vector offsets from `VEC_BASE` are 0x00 for reset, 0x04 for undefined, 0x08 for software interrupt, 0x0C for prefetch abort, 0x10 for data abort, 0x18 for normal interrupt and 0x1C for fast interrupt.
- R2: Status bit 6 is the normal-interrupt mask and bit 5 is the fast-interrupt mask. While a mask bit is 1, its interrupt line is never taken. Once the bit is 0 again, the line is taken if it is still held.
- R3: Both interrupt lines pass through `SYNC_STAGES` flip-flops (default 2). A line that goes high before clock edge k can first produce an entry in the cycle after edge k+`SYNC_STAGES`-1, and no earlier.
- R4: Every entry other than reset happens only in a cycle where `boundary_i` is high. `take_o` is raised in that same cycle.
- R5: The four synchronous flags are single-cycle pulses. Each one is captured and held pending until its entry is taken, so a flag that arrives between boundaries, or that loses arbitration, is taken at a later boundary.
- R6: If a data abort and an unmasked fast interrupt compete, the data abort is entered first and the fast-interrupt mask is left as it was. The fast interrupt is then entered at the next boundary, provided its mask is still clear.
- R7: On every entry `vec_o` equals `VEC_BASE` plus the offset from R1. `save_ret_o` and `save_stat_o` follow `take_o` for every entry except reset. All three outputs are low when nothing is taken.
- R8: `mode_o` uses five-bit encodings: supervisor 0x13 for reset and software interrupt, abort 0x17 for both aborts, undefined 0x1B, normal interrupt 0x12, fast interrupt 0x11. User mode is 0x10.
- R9: Every entry sets `irq_mask_o`. Reset and fast-interrupt entries also set `fiq_mask_o`. All other entries pass the current fast mask through unchanged.
- R10: If the undefined and software-interrupt flags are pending together, only the undefined entry is taken, and the software-interrupt flag is discarded.
- R11: `take_o` pulses once, in the first cycle `rst_req_i` is high, regardless of `boundary_i`. No entry happens while the request stays high after that, and every synchronous flag that is pending or arriving during the request is discarded.
- R12: Each entry produces exactly one `take_o` cycle. The flag that was taken is cleared, so a later boundary with no new event produces no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| rst_req_i | input | 1 | Level-sensitive core reset request |
| dabt_i | input | 1 | Data abort pulse |
| pabt_i | input | 1 | Prefetch abort pulse |
| undef_i | input | 1 | Undefined instruction pulse |
| swi_i | input | 1 | Software interrupt pulse |
| fiq_req_i | input | 1 | Asynchronous fast interrupt line |
| irq_req_i | input | 1 | Asynchronous normal interrupt line |
| boundary_i | input | 1 | High in the last cycle of an instruction |
| status_i | input | 7 | Current status: [6] normal mask, [5] fast mask, [4:0] mode |
| take_o | output | 1 | Entry taken this cycle |
| vec_o | output | ADDR_W | Vector address of the entry |
| mode_o | output | 5 | New mode |
| irq_mask_o | output | 1 | New normal-interrupt mask |
| fiq_mask_o | output | 1 | New fast-interrupt mask |
| save_ret_o | output | 1 | Capture the return address |
| save_stat_o | output | 1 | Capture the status word |

## Verification
Directed sequences apply single events, events that compete, flags that arrive away from a boundary, interrupts held behind a mask, and a reset request held for several cycles. Each sequence separates one rule from its neighbours: where a request is kept pending, which event wins, how long the synchronizer delays a line, and what reset discards. A long run of seeded random pulses, interrupt levels, boundary strobes and mask rewrites then covers the interleavings that the directed cases leave out. The expected entry kind for every cycle is predicted and compared against all outputs.

// File: rtl/exc_pkg.sv
package exc_pkg;

    localparam int MODE_W = 5;
    localparam int STAT_W = 7;
    localparam int I_BIT  = 6;
    localparam int F_BIT  = 5;

    typedef logic [MODE_W-1:0] mode_t;

    localparam mode_t MD_USER = 5'h10;
    localparam mode_t MD_FAST = 5'h11;
    localparam mode_t MD_INTR = 5'h12;
    localparam mode_t MD_SUPV = 5'h13;
    localparam mode_t MD_ABRT = 5'h17;
    localparam mode_t MD_UNDF = 5'h1B;

    typedef enum logic [2:0] {
        EK_NONE, EK_RESET, EK_DABT, EK_FIQ, EK_IRQ, EK_PABT, EK_UNDEF, EK_SWI
    } exc_kind_e;

    typedef struct packed {
        logic dabt;
        logic pabt;
        logic undef;
        logic swi;
    } sync_flags_t;

    typedef struct packed {
        logic  irq_mask;
        logic  fiq_mask;
        mode_t mode;
    } entry_state_t;

    function automatic logic [7:0] vec_offset(exc_kind_e k);
        case (k)
            EK_UNDEF: return 8'h04;
            EK_SWI:   return 8'h08;
            EK_PABT:  return 8'h0C;
            EK_DABT:  return 8'h10;
            EK_IRQ:   return 8'h18;
            EK_FIQ:   return 8'h1C;
            default:  return 8'h00;
        endcase
    endfunction

    function automatic mode_t entry_mode(exc_kind_e k);
        case (k)
            EK_DABT, EK_PABT: return MD_ABRT;
            EK_UNDEF:         return MD_UNDF;
            EK_IRQ:           return MD_INTR;
            EK_FIQ:           return MD_FAST;
            default:          return MD_SUPV;
        endcase
    endfunction

    function automatic logic is_valid_mode(mode_t m);
        return (m == MD_USER) || (m == MD_FAST) || (m == MD_INTR) ||
               (m == MD_SUPV) || (m == MD_ABRT) || (m == MD_UNDF);
    endfunction

endpackage

// File: rtl/exc_sync.sv
module exc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= 1'b0;
                    else     chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_pkg::*;
(
    input  logic        rst,
    input  logic        rst_req,
    input  logic        rst_seen,
    input  logic        boundary,
    input  sync_flags_t pend,
    input  logic        fiq_ok,
    input  logic        irq_ok,
    output exc_kind_e   kind
);
    always_comb begin
        kind = EK_NONE;
        if (rst) begin
            kind = EK_NONE;
        end else if (rst_req) begin
            kind = rst_seen ? EK_NONE : EK_RESET;
        end else if (boundary) begin
            if (pend.dabt)       kind = EK_DABT;
            else if (fiq_ok)     kind = EK_FIQ;
            else if (irq_ok)     kind = EK_IRQ;
            else if (pend.pabt)  kind = EK_PABT;
            else if (pend.undef) kind = EK_UNDEF;
            else if (pend.swi)   kind = EK_SWI;
        end
    end
endmodule

// File: rtl/exc_entry.sv
module exc_entry
    import exc_pkg::*;
#(
    parameter int                ADDR_W   = 32,
    parameter logic [ADDR_W-1:0] VEC_BASE = '0
) (
    input  exc_kind_e         kind,
    input  logic [STAT_W-1:0] status,
    output logic [ADDR_W-1:0] vec,
    output entry_state_t      nxt,
    output logic              save_ret,
    output logic              save_stat
);
    logic take;
    assign take = (kind != EK_NONE);

    always_comb begin
        nxt.irq_mask = status[I_BIT];
        nxt.fiq_mask = status[F_BIT];
        nxt.mode     = status[MODE_W-1:0];
        vec          = '0;
        if (take) begin
            vec          = VEC_BASE + ADDR_W'(vec_offset(kind));
            nxt.mode     = entry_mode(kind);
            nxt.irq_mask = 1'b1;
            if (kind == EK_RESET || kind == EK_FIQ) nxt.fiq_mask = 1'b1;
        end
    end

    assign save_ret  = take && (kind != EK_RESET);
    assign save_stat = take && (kind != EK_RESET);
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_pkg::*;
#(
    parameter int                ADDR_W      = 32,
    parameter logic [ADDR_W-1:0] VEC_BASE    = '0,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rst_req_i,
    input  logic              dabt_i,
    input  logic              pabt_i,
    input  logic              undef_i,
    input  logic              swi_i,
    input  logic              fiq_req_i,
    input  logic              irq_req_i,
    input  logic              boundary_i,
    input  logic [STAT_W-1:0] status_i,
    output logic              take_o,
    output logic [ADDR_W-1:0] vec_o,
    output logic [MODE_W-1:0] mode_o,
    output logic              irq_mask_o,
    output logic              fiq_mask_o,
    output logic              save_ret_o,
    output logic              save_stat_o
);
    logic         rst_seen;
    logic         fiq_s, irq_s;
    sync_flags_t  pend_q, cur, clr;
    exc_kind_e    kind;
    entry_state_t nxt;

    always_ff @(posedge clk) begin
        if (rst) rst_seen <= 1'b0;
        else     rst_seen <= rst_req_i;
    end

    exc_sync #(.STAGES(SYNC_STAGES)) u_fsync (
        .clk(clk), .rst(rst), .async_i(fiq_req_i), .sync_o(fiq_s)
    );
    exc_sync #(.STAGES(SYNC_STAGES)) u_isync (
        .clk(clk), .rst(rst), .async_i(irq_req_i), .sync_o(irq_s)
    );

    always_comb begin
        cur.dabt  = pend_q.dabt  | dabt_i;
        cur.pabt  = pend_q.pabt  | pabt_i;
        cur.undef = pend_q.undef | undef_i;
        cur.swi   = pend_q.swi   | swi_i;
    end

    exc_arbiter u_arb (
        .rst      (rst),
        .rst_req  (rst_req_i),
        .rst_seen (rst_seen),
        .boundary (boundary_i),
        .pend     (cur),
        .fiq_ok   (fiq_s & ~status_i[F_BIT]),
        .irq_ok   (irq_s & ~status_i[I_BIT]),
        .kind     (kind)
    );

    always_comb begin
        clr.dabt  = (kind == EK_DABT);
        clr.pabt  = (kind == EK_PABT);
        clr.undef = (kind == EK_UNDEF) || (kind == EK_SWI);
        clr.swi   = (kind == EK_UNDEF) || (kind == EK_SWI);
    end

    always_ff @(posedge clk) begin
        if (rst || rst_req_i) pend_q <= '0;
        else                  pend_q <= sync_flags_t'(cur & ~clr);
    end

    exc_entry #(.ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE)) u_entry (
        .kind      (kind),
        .status    (status_i),
        .vec       (vec_o),
        .nxt       (nxt),
        .save_ret  (save_ret_o),
        .save_stat (save_stat_o)
    );

    assign take_o     = (kind != EK_NONE);
    assign mode_o     = nxt.mode;
    assign irq_mask_o = nxt.irq_mask;
    assign fiq_mask_o = nxt.fiq_mask;
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
    import exc_pkg::*;
#(
    parameter int                ADDR_W   = 32,
    parameter logic [ADDR_W-1:0] VEC_BASE = '0
) (
    input logic              clk,
    input logic              rst,
    input logic              rst_req_i,
    input logic              rst_seen,
    input logic              dabt_i,
    input logic              boundary_i,
    input logic [STAT_W-1:0] status_i,
    input logic              take_o,
    input logic [ADDR_W-1:0] vec_o,
    input logic [MODE_W-1:0] mode_o,
    input logic              irq_mask_o,
    input logic              save_ret_o,
    input logic              save_stat_o
);
    assert_dabt_wins_R1: assert property (@(posedge clk) disable iff (rst)
        (take_o && !rst_req_i && dabt_i) |-> (vec_o == VEC_BASE + ADDR_W'(8'h10)));

    assert_irq_masked_R2: assert property (@(posedge clk) disable iff (rst)
        (take_o && vec_o == VEC_BASE + ADDR_W'(8'h18)) |-> !status_i[I_BIT]);

    assert_fiq_masked_R2: assert property (@(posedge clk) disable iff (rst)
        (take_o && vec_o == VEC_BASE + ADDR_W'(8'h1C)) |-> !status_i[F_BIT]);

    assert_on_boundary_R4: assert property (@(posedge clk) disable iff (rst)
        (take_o && !rst_req_i) |-> boundary_i);

    assert_save_on_entry_R7: assert property (@(posedge clk) disable iff (rst)
        (take_o && !rst_req_i) |-> (save_ret_o && save_stat_o));

    assert_no_save_idle_R7: assert property (@(posedge clk) disable iff (rst)
        !take_o |-> (!save_ret_o && !save_stat_o));

    assert_mode_valid_R8: assert property (@(posedge clk) disable iff (rst)
        take_o |-> is_valid_mode(mode_o));

    assert_irq_mask_set_R9: assert property (@(posedge clk) disable iff (rst)
        take_o |-> irq_mask_o);

    assert_reset_held_R11: assert property (@(posedge clk) disable iff (rst)
        (rst_req_i && rst_seen) |-> !take_o);
endmodule

bind exc_entry_ctrl exc_entry_chk #(.ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .rst_req_i   (rst_req_i),
    .rst_seen    (rst_seen),
    .dabt_i      (dabt_i),
    .boundary_i  (boundary_i),
    .status_i    (status_i),
    .take_o      (take_o),
    .vec_o       (vec_o),
    .mode_o      (mode_o),
    .irq_mask_o  (irq_mask_o),
    .save_ret_o  (save_ret_o),
    .save_stat_o (save_stat_o)
);

// File: tb/sim_exc_entry_ctrl.sv
`timescale 1ns/1ps
module sim_exc_entry_ctrl;
    localparam int ADDR_W = 32;
    localparam logic [31:0] BASE = 32'h0000_0000;

    localparam int K_NONE = 0, K_RST = 1, K_DABT = 2, K_FIQ = 3,
                   K_IRQ = 4, K_PABT = 5, K_UND = 6, K_SWI = 7;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rst_req_i = 0, dabt_i = 0, pabt_i = 0, undef_i = 0, swi_i = 0;
    logic fiq_req_i = 0, irq_req_i = 0, boundary_i = 0;
    logic [6:0] status_i = 7'h00;
    logic take_o, irq_mask_o, fiq_mask_o, save_ret_o, save_stat_o;
    logic [ADDR_W-1:0] vec_o;
    logic [4:0] mode_o;

    // values the next step applies at the falling edge
    logic n_rreq = 0, n_dabt = 0, n_pabt = 0, n_und = 0, n_swi = 0;
    logic n_fiq = 0, n_irq = 0, n_bnd = 0;

    // reference state
    logic       m_rstq = 0;
    logic [3:0] m_pend = 0;   // [0] dabt [1] pabt [2] undef [3] swi
    logic [1:0] m_fs = 0, m_is = 0;
    logic [6:0] m_st = 7'h00; // [6] normal mask [5] fast mask [4:0] mode

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    exc_entry_ctrl #(.ADDR_W(ADDR_W), .VEC_BASE(BASE), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst(rst), .rst_req_i(rst_req_i), .dabt_i(dabt_i),
        .pabt_i(pabt_i), .undef_i(undef_i), .swi_i(swi_i),
        .fiq_req_i(fiq_req_i), .irq_req_i(irq_req_i), .boundary_i(boundary_i),
        .status_i(status_i), .take_o(take_o), .vec_o(vec_o), .mode_o(mode_o),
        .irq_mask_o(irq_mask_o), .fiq_mask_o(fiq_mask_o),
        .save_ret_o(save_ret_o), .save_stat_o(save_stat_o)
    );

    function automatic logic [31:0] exp_vec(int k);
        case (k)
            K_UND:  return BASE + 32'h04;
            K_SWI:  return BASE + 32'h08;
            K_PABT: return BASE + 32'h0C;
            K_DABT: return BASE + 32'h10;
            K_IRQ:  return BASE + 32'h18;
            K_FIQ:  return BASE + 32'h1C;
            default: return BASE;
        endcase
    endfunction

    function automatic logic [4:0] exp_mode(int k);
        case (k)
            K_DABT, K_PABT: return 5'h17;
            K_UND:          return 5'h1B;
            K_IRQ:          return 5'h12;
            K_FIQ:          return 5'h11;
            default:        return 5'h13;
        endcase
    endfunction

    function automatic int exp_kind();
        logic [3:0] cur;
        cur = m_pend | {n_swi, n_und, n_pabt, n_dabt};
        if (n_rreq) return m_rstq ? K_NONE : K_RST;
        if (!n_bnd) return K_NONE;
        if (cur[0]) return K_DABT;
        if (m_fs[1] && !m_st[5]) return K_FIQ;
        if (m_is[1] && !m_st[6]) return K_IRQ;
        if (cur[1]) return K_PABT;
        if (cur[2]) return K_UND;
        if (cur[3]) return K_SWI;
        return K_NONE;
    endfunction

    task automatic check(input string req, input bit ok, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic step(input string req);
        int k;
        bit efm;
        logic [3:0] clr;
        @(negedge clk);
        rst_req_i = n_rreq; dabt_i = n_dabt; pabt_i = n_pabt; undef_i = n_und;
        swi_i = n_swi; fiq_req_i = n_fiq; irq_req_i = n_irq; boundary_i = n_bnd;
        status_i = m_st;
        #1;
        k = exp_kind();
        efm = (k == K_RST || k == K_FIQ) ? 1'b1 : m_st[5];
        check(req, take_o == (k != K_NONE), "take", 32'(take_o), 32'(k != K_NONE));
        if (k != K_NONE) begin
            check(req, vec_o == exp_vec(k), "vector", vec_o, exp_vec(k));
            check(req, mode_o == exp_mode(k), "mode", 32'(mode_o), 32'(exp_mode(k)));
            check(req, {irq_mask_o, fiq_mask_o} == {1'b1, efm}, "masks",
                  32'({irq_mask_o, fiq_mask_o}), 32'({1'b1, efm}));
            check(req, {save_ret_o, save_stat_o} == {2{k != K_RST}}, "saves",
                  32'({save_ret_o, save_stat_o}), 32'({2{k != K_RST}}));
        end else begin
            check(req, {save_ret_o, save_stat_o} == 2'b00, "saves idle",
                  32'({save_ret_o, save_stat_o}), 32'd0);
        end
        @(posedge clk);
        clr = {k == K_UND || k == K_SWI, k == K_UND || k == K_SWI, k == K_PABT, k == K_DABT};
        if (n_rreq) m_pend = '0;
        else        m_pend = (m_pend | {n_swi, n_und, n_pabt, n_dabt}) & ~clr;
        m_rstq = n_rreq;
        m_fs = {m_fs[0], n_fiq};
        m_is = {m_is[0], n_irq};
        if (k != K_NONE) m_st = {1'b1, efm, exp_mode(k)};
        n_dabt = 0; n_pabt = 0; n_und = 0; n_swi = 0;
    endtask

    task automatic idle(input int n, input string req);
        for (int i = 0; i < n; i++) step(req);
    endtask

    task automatic summary();
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R4", take_o == 1'b0, "reset state take", 32'(take_o), 0);
        check("R7", {save_ret_o, save_stat_o} == 2'b00, "reset state saves",
              32'({save_ret_o, save_stat_o}), 0);

        // R11: reset request held; flags during it are dropped
        n_rreq = 1; n_bnd = 0; step("R11");
        n_dabt = 1; n_bnd = 1; step("R11");
        n_swi = 1; step("R11");
        n_rreq = 0; n_bnd = 1; idle(2, "R11");

        // R5: flag between boundaries, held until one arrives
        m_st = {2'b00, 5'h10};
        n_bnd = 0; n_pabt = 1; step("R5");
        idle(3, "R5");
        n_bnd = 1; step("R5");
        idle(2, "R12");

        // R6: data abort competes with an unmasked fast interrupt
        m_st = {2'b00, 5'h10};
        n_bnd = 0; n_fiq = 1; idle(3, "R3");
        n_bnd = 1; n_dabt = 1; step("R6");
        step("R6");
        n_fiq = 0; n_bnd = 0; idle(3, "R6");

        // R2: normal interrupt held behind its mask
        m_st = {2'b10, 5'h10};
        n_irq = 1; n_bnd = 1; idle(5, "R2");
        m_st = {2'b00, 5'h10};
        step("R2");
        n_irq = 0; idle(4, "R2");
        m_st = {2'b01, 5'h10};
        n_fiq = 1; idle(4, "R2");
        n_fiq = 0; idle(3, "R2");

        // R3: exact synchronizer delay with boundary high every cycle
        m_st = {2'b00, 5'h10};
        n_bnd = 1; n_irq = 1; step("R3"); step("R3"); step("R3");
        n_irq = 0; idle(3, "R3");

        // R10: undefined and software interrupt together
        m_st = {2'b00, 5'h10};
        n_und = 1; n_swi = 1; step("R10");
        idle(2, "R10");
        n_swi = 1; step("R8");

        // R1: everything at once, then drain
        m_st = {2'b00, 5'h10};
        n_fiq = 1; n_irq = 1; n_bnd = 0; idle(3, "R1");
        n_dabt = 1; n_pabt = 1; n_und = 1; n_bnd = 1; step("R1");
        step("R1");
        m_st = {2'b00, 5'h10}; step("R1");
        n_fiq = 0; n_irq = 0; idle(2, "R1");
        m_st = {2'b00, 5'h10}; idle(3, "R1");

        // R9, R7, R12: seeded random traffic
        for (int c = 0; c < 4000; c++) begin
            n_rreq = ($urandom_range(0, 199) == 0) ? ~n_rreq : (n_rreq && $urandom_range(0, 3) != 0);
            n_dabt = ($urandom_range(0, 15) == 0);
            n_pabt = ($urandom_range(0, 15) == 0);
            n_und  = ($urandom_range(0, 19) == 0);
            n_swi  = ($urandom_range(0, 19) == 0);
            if ($urandom_range(0, 11) == 0) n_fiq = ~n_fiq;
            if ($urandom_range(0, 9) == 0)  n_irq = ~n_irq;
            n_bnd = ($urandom_range(0, 2) != 0);
            if ($urandom_range(0, 7) == 0) m_st = {2'($urandom_range(0, 3)), 5'h10};
            step("R9");
        end
        n_rreq = 0; n_fiq = 0; n_irq = 0; n_bnd = 1;
        idle(4, "R12");

        summary();
        $finish;
    end
endmodule